// File: doc/BRIEF.md
# Coherency Unit Event Monitor

A register-mapped block that counts occurrences of up to eight hardware events. An eight-bit event vector comes in from the surrounding logic. Each of the eight 32-bit counters has a selector byte that picks one bit of that vector. The counter then advances by one on every clock in which that bit is high and a global run bit is set. When a counter rolls over from all-ones to zero, it latches an overflow flag. The flag drives that counter's own interrupt line if the counter's interrupt is unmasked.

Software drives the block through a plain single-cycle register port with per-byte write strobes. To sample every N events, software writes a counter with the two's complement of N, picks an event, unmasks the interrupt and sets the run bit. On each interrupt it clears the flag by writing one to it and reloads the counter. The meaning of each event bit is defined by whatever drives the event vector.

Top module: `pmon_top`

## Requirements
- R1: After reset every counter, selector byte, enable and flag is zero, every register reads 0 and all eight interrupt lines are low.
- R2: The register port uses word addresses (byte offset divided by 4), and reads are combinational in the same cycle. Word 0 is control. Word 1 holds selectors 0..3 in byte lanes 0..3. Word 2 holds selectors 4..7 in byte lanes 0..3. Words 3..10 hold counters 0..7. Words 11..15 read 0 and ignore writes.
- R3: Control bit 0 is the run bit, bits 15:8 are the interrupt masks for counters 0..7 (1 = enabled) and bits 23:16 are the overflow flags for counters 0..7. Bits 7:1 and 31:24 read 0 and ignore writes.
- R4: A selector code k in 1..8 makes its counter add one on each clock edge at which event bit k-1 is high. Code 0 and codes 9..255 keep the counter idle.
- R5: While the run bit is 0, no counter changes except by a register write.
- R6: A counter that steps from 0xFFFFFFFF to 0 sets its flag at that same edge.
- R7: Writing 1 to a flag bit (with byte lane 2 enabled) clears it, and writing 0 leaves it alone. A rollover at the same edge as a clear leaves the flag set.
- R8: Interrupt line i is high exactly while flag i and mask bit i are both 1. Clearing the mask does not stop counting.
- R9: A register write to a counter wins over an increment at the same edge.
- R10: Writes honour the byte strobes: lane j of the strobe updates bits 8j+7:8j only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_be | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read request |
| ev_i | input | 8 | Event vector |
| irq_o | output | 8 | One interrupt per counter |

## Verification
A corrupted counter or selector shows up at the port on the next read of that counter. A stuck flag or mask shows on the interrupt lines one edge after the rollover or after the write that should have changed it. The bench therefore follows each rollover, mask change and flag clear with an interrupt check on the next cycle and a control read. It places a rollover and a flag clear on the same edge, and a counter write and an increment on the same edge, so that an ordering fault leaves a wrong value that stays readable.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int NUM_CTR  = 8;
    localparam int CTR_W    = 32;
    localparam int EV_W     = 8;
    localparam int CODE_W   = 8;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int LANES    = BUS_W / 8;
    localparam int SEL_BASE = 1;
    localparam int CNT_BASE = SEL_BASE + (NUM_CTR * CODE_W) / BUS_W;
    localparam int IE_LSB   = 8;
    localparam int FLAG_LSB = 16;

    function automatic logic [BUS_W-1:0] merge_lanes(
        input logic [BUS_W-1:0] old_v,
        input logic [BUS_W-1:0] new_v,
        input logic [LANES-1:0] be);
        logic [BUS_W-1:0] r;
        r = old_v;
        for (int j = 0; j < LANES; j++)
            if (be[j]) r[8*j +: 8] = new_v[8*j +: 8];
        return r;
    endfunction
endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
    import pmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [2:0]         be_i,
    input  logic               run_d_i,
    input  logic [NUM_CTR-1:0] ie_d_i,
    input  logic [NUM_CTR-1:0] clr_d_i,
    input  logic [NUM_CTR-1:0] wrap_i,
    output logic               run_o,
    output logic [NUM_CTR-1:0] ie_o,
    output logic [NUM_CTR-1:0] flag_o
);
    logic [NUM_CTR-1:0] clr_mask;

    assign clr_mask = (wr_i && be_i[2]) ? clr_d_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o  <= 1'b0;
            ie_o   <= '0;
            flag_o <= '0;
        end else begin
            if (wr_i && be_i[0]) run_o <= run_d_i;
            if (wr_i && be_i[1]) ie_o  <= ie_d_i;
            flag_o <= (flag_o & ~clr_mask) | wrap_i;
        end
    end

    // R6: a rollover always leaves its flag set
    assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_i) |=> ((flag_o & $past(wrap_i)) == $past(wrap_i)));

    // R7: a one written to a flag clears it unless a rollover coincides
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && be_i[2]) |=> ((flag_o & $past(clr_d_i & ~wrap_i)) == '0));
endmodule

// File: rtl/pmon_slot.sv
module pmon_slot
    import pmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [EV_W-1:0]   ev_i,
    input  logic              sel_wr_i,
    input  logic [CODE_W-1:0] sel_d_i,
    input  logic              cnt_wr_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CTR_W-1:0]  cnt_o,
    output logic              wrap_o
);
    logic hit;
    logic step;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < EV_W; k++)
            if (code_o == CODE_W'(k + 1) && ev_i[k]) hit = 1'b1;
    end

    assign step   = run_i && hit && !cnt_wr_i;
    assign wrap_o = step && (cnt_o == {CTR_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            cnt_o  <= '0;
        end else begin
            if (sel_wr_i) code_o <= sel_d_i;
            if (cnt_wr_i)
                cnt_o <= merge_lanes(cnt_o, wdata_i, be_i);
            else if (step)
                cnt_o <= cnt_o + 1'b1;
        end
    end

    // R5: a stopped monitor holds every counter
    assert_frozen_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_wr_i) |=> $stable(cnt_o));

    // R4: a matching event while running adds exactly one
    assert_counts_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && hit && !cnt_wr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pmon_top.sv
module pmon_top
    import pmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [LANES-1:0]   bus_be,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [EV_W-1:0]    ev_i,
    output logic [NUM_CTR-1:0] irq_o
);
    localparam int SEL_PER_WORD = BUS_W / CODE_W;

    logic                     wr;
    logic                     run;
    logic [NUM_CTR-1:0]       ie;
    logic [NUM_CTR-1:0]       flag;
    logic [NUM_CTR-1:0]       wrap;
    logic [CODE_W-1:0]        code [NUM_CTR];
    logic [CTR_W-1:0]         cnt  [NUM_CTR];

    assign wr = bus_req && bus_we;

    pmon_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr && bus_addr == '0),
        .be_i    (bus_be[2:0]),
        .run_d_i (bus_wdata[0]),
        .ie_d_i  (bus_wdata[IE_LSB +: NUM_CTR]),
        .clr_d_i (bus_wdata[FLAG_LSB +: NUM_CTR]),
        .wrap_i  (wrap),
        .run_o   (run),
        .ie_o    (ie),
        .flag_o  (flag)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        localparam int SW = SEL_BASE + i / SEL_PER_WORD;
        localparam int SL = i % SEL_PER_WORD;
        pmon_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run),
            .ev_i     (ev_i),
            .sel_wr_i (wr && bus_addr == ADDR_W'(SW) && bus_be[SL]),
            .sel_d_i  (bus_wdata[CODE_W*SL +: CODE_W]),
            .cnt_wr_i (wr && bus_addr == ADDR_W'(CNT_BASE + i)),
            .be_i     (bus_be),
            .wdata_i  (bus_wdata),
            .code_o   (code[i]),
            .cnt_o    (cnt[i]),
            .wrap_o   (wrap[i])
        );
    end

    assign irq_o = flag & ie;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            bus_rdata[0]                    = run;
            bus_rdata[IE_LSB +: NUM_CTR]   = ie;
            bus_rdata[FLAG_LSB +: NUM_CTR] = flag;
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (bus_addr == ADDR_W'(SEL_BASE + i / SEL_PER_WORD))
                bus_rdata[CODE_W*(i % SEL_PER_WORD) +: CODE_W] = code[i];
            if (bus_addr == ADDR_W'(CNT_BASE + i))
                bus_rdata = cnt[i];
        end
    end

    // R3: unused control bits always read as zero
    assert_ctrl_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == '0) |-> (bus_rdata[7:1] == '0 && bus_rdata[31:24] == '0));
endmodule

// File: tb/pmon_top_tb_top.sv
module pmon_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ev_i = '0;
    logic [7:0]  irq_o;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pmon_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ev_i(ev_i), .irq_o(irq_o)
    );

    // monitor: pops the expected read value and compares
    always @(negedge clk) begin
        if (bus_req && !bus_we && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (bus_rdata !== e) begin
                bad++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d, input logic [7:0] ev);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d; ev_i = ev;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = '0; ev_i = '0;
    endtask

    task automatic idle(input logic [7:0] ev, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            bus_req = 1'b0; bus_we = 1'b0; ev_i = ev;
        end
    endtask

    task automatic chk_irq(input logic [7:0] e, input string t);
        idle(8'h00, 1);
        @(negedge clk);
        total++;
        if (irq_o !== e) begin
            bad++;
            $display("FAIL %s: irq got %h expected %h", t, irq_o, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 32'h0, "R1 ctrl after reset");
        rd(4'd1, 32'h0, "R1 selectors after reset");
        rd(4'd3, 32'h0, "R1 counter0 after reset");
        chk_irq(8'h00, "R1 irq after reset");
        // R6 R8 rollover raises flag and interrupt
        wr(4'd3, 4'hF, 32'hFFFF_FFFD, 8'h00);
        wr(4'd1, 4'h1, 32'h0000_0001, 8'h00);
        wr(4'd0, 4'hF, 32'h0000_0101, 8'h00);
        idle(8'h01, 3);
        rd(4'd3, 32'h0, "R6 counter0 wrapped");
        rd(4'd0, 32'h0001_0101, "R6 flag0 set");
        chk_irq(8'h01, "R8 irq0 asserted");
        // R8 masking keeps counting; R7 zero write keeps flag
        wr(4'd0, 4'h7, 32'h0000_0001, 8'h00);
        chk_irq(8'h00, "R8 irq0 masked");
        idle(8'h01, 5);
        rd(4'd3, 32'd5, "R8 counter0 runs while masked");
        rd(4'd0, 32'h0001_0001, "R7 zero write leaves flag");
        // R7 write-one clears
        wr(4'd0, 4'h4, 32'h0001_0000, 8'h00);
        rd(4'd0, 32'h0000_0001, "R7 flag0 cleared");
        // R5 global stop
        wr(4'd0, 4'h1, 32'h0, 8'h00);
        idle(8'hFF, 4);
        rd(4'd3, 32'd5, "R5 counter0 frozen");
        wr(4'd0, 4'h1, 32'h1, 8'h00);
        // R4 code 0, code 9, code 8
        idle(8'hFF, 3);
        rd(4'd4, 32'd0, "R4 code 0 idle");
        wr(4'd1, 4'h2, 32'h0000_0900, 8'h00);
        idle(8'hFF, 2);
        rd(4'd4, 32'd0, "R4 code 9 idle");
        wr(4'd1, 4'h2, 32'h0000_0800, 8'h00);
        idle(8'h80, 6);
        rd(4'd4, 32'd6, "R4 code 8 counts bit 7");
        idle(8'h7F, 2);
        rd(4'd4, 32'd6, "R4 code 8 ignores other bits");
        rd(4'd1, 32'h0000_0801, "R2 selector lanes");
        rd(4'd3, 32'd12, "R4 counter0 total");
        // R9 write beats increment
        wr(4'd3, 4'hF, 32'd100, 8'h01);
        rd(4'd3, 32'd100, "R9 write wins");
        // R7 clear and rollover on the same edge
        wr(4'd5, 4'hF, 32'hFFFF_FFFF, 8'h00);
        wr(4'd1, 4'h4, 32'h0002_0000, 8'h00);
        wr(4'd0, 4'h3, 32'h0000_0401, 8'h00);
        wr(4'd0, 4'h4, 32'h0004_0000, 8'h02);
        rd(4'd0, 32'h0004_0401, "R7 rollover beats clear");
        rd(4'd5, 32'h0, "R6 counter2 wrapped");
        chk_irq(8'h04, "R8 only irq2 asserted");
        wr(4'd0, 4'h4, 32'h0004_0000, 8'h00);
        rd(4'd0, 32'h0000_0401, "R7 flag2 cleared");
        chk_irq(8'h00, "R8 irq2 dropped");
        // R10 byte strobes
        wr(4'd6, 4'hF, 32'hAABB_CCDD, 8'h00);
        wr(4'd6, 4'h2, 32'h1122_3344, 8'h00);
        rd(4'd6, 32'hAABB_33DD, "R10 lane 1 only");
        // R3 reserved bits, R2 unmapped words
        wr(4'd0, 4'hF, 32'hFFFF_FFFF, 8'h00);
        rd(4'd0, 32'h0000_FF01, "R3 reserved read zero");
        wr(4'd12, 4'hF, 32'hFFFF_FFFF, 8'h00);
        rd(4'd12, 32'h0, "R2 unmapped word");
        rd(4'd2, 32'h0, "R2 upper selectors untouched");
        idle(8'h00, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule